// File: doc/BRIEF.md
# Message Link Integrity Checker

This block sits in line on one link of a wormhole-routed network and watches every message that crosses it. It passes the word stream straight through, recomputes a 16-bit CRC over the message on the fly, and judges the trailer when it arrives. A trailer that matches the computed CRC goes through untouched. A trailer that matches neither the computed CRC nor its complement marks a fresh corruption: the block raises a primary error and overwrites the trailer with the complement of the correct CRC. A trailer that already holds that complement shows that an earlier stage caught the fault, so this block raises only a secondary error. A chain of such checkers therefore reports one primary error at the faulty link, followed by secondary errors downstream.

Each message is one header word, then as many 32-bit data words as the header's length field says, then one trailer word. The block keeps a running count of the messages it has passed, so that totals can be compared across links to find lost or duplicated messages. The block holds no words itself. It is a combinational pass-through with a three-state frame tracker beside the stream.

The frame tracker has three states. HDR waits for a header. BODY counts data words. TAIL waits for the trailer. The transitions are: HDR to BODY when a header with a nonzero length is accepted; HDR to TAIL when a header with length zero is accepted; BODY to TAIL when the last data word is accepted; TAIL to HDR when the trailer is accepted. No state changes without a handshake.

Top module: `msg_link_checker`

## Requirements
- R1: A message is a header word, then L data words, then one trailer word. In the header, bits [3:0] are the tag, bits [7:4] are the length L, and bits [31:8] are routing. The frame follows L as received, for any value 0 to 15. The trailer carries the CRC in bits [15:0].
- R2: The CRC uses polynomial 0x1021 and starts from 0xFFFF. It covers the header word and the data words, each word fed most significant bit first, with no reflection and no final XOR.
- R3: When the trailer CRC equals the computed CRC and the length is legal, every word is forwarded unchanged and neither error output pulses.
- R4: When the trailer CRC equals neither the computed CRC nor its complement, err_primary is high for exactly the one cycle after the trailer handshake. The forwarded trailer has bits [15:0] replaced by the complement of the computed CRC and bits [31:16] unchanged.
- R5: When the trailer CRC equals the complement of the computed CRC, err_secondary is high for exactly the one cycle after the trailer handshake, err_primary stays low, and the trailer is forwarded unchanged. The two error outputs are never high together.
- R6: A length of 0 or 6 to 15 is illegal. With a trailer that is not the complement, it gives a primary error and trailer replacement as in R4. With a complemented trailer, it gives a secondary error as in R5.
- R7: msg_count is 0 after reset and rises by one in the cycle after each trailer handshake, whether the message is good or bad.
- R8: out_valid follows in_valid and in_ready follows out_ready in the same cycle. Header and data words, and trailer bits [31:16], are forwarded unchanged.
- R9: While in_valid is high and out_ready is low, the frame position, msg_count and error outputs do not change.
- R10: While reset is held, err_primary and err_secondary are low, msg_count is 0, and the next accepted word is taken as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Upstream may advance (follows out_ready) |
| in_data | input | 32 | Upstream word |
| out_valid | output | 1 | Downstream word valid (follows in_valid) |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Forwarded word, trailer possibly rewritten |
| err_primary | output | 1 | One-cycle pulse for a fresh corruption |
| err_secondary | output | 1 | One-cycle pulse for a corruption already marked upstream |
| msg_count | output | CNT_W | Number of messages passed |

## Verification
The verdict on a message is registered, so its error pulse and count step appear in the cycle after the trailer handshake. When messages run back to back, that is the same cycle in which the next header is accepted and its CRC seeding starts. The bench sends messages with no idle gap between them, including a corrupted one followed at once by a good one. It checks that the pulse and count belong to the earlier message while the following header still passes unchanged and its own verdict comes out clean. It also holds out_ready low on trailer beats to check that the verdict waits for the handshake.

// File: rtl/msg_link_pkg.sv
`timescale 1ns/1ps
package msg_link_pkg;
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_BODY = 2'd1,
        ST_TAIL = 2'd2
    } frame_st_e;
endpackage

// File: rtl/msg_link_crc.sv
`timescale 1ns/1ps
module msg_link_crc #(
    parameter int          DATA_W = 32,
    parameter int          CRC_W  = 16,
    parameter logic [15:0] POLY   = 16'h1021,
    parameter logic [15:0] SEED   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat,
    input  logic              at_hdr,
    input  logic              at_tail,
    input  logic [DATA_W-1:0] word,
    output logic [CRC_W-1:0]  crc_run
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_d;

    always_comb begin
        logic fb;
        crc_d = at_hdr ? SEED[CRC_W-1:0] : crc_q;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb    = crc_d[CRC_W-1] ^ word[i];
            crc_d = {crc_d[CRC_W-2:0], 1'b0};
            if (fb) crc_d = crc_d ^ POLY[CRC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                crc_q <= SEED[CRC_W-1:0];
        else if (beat && !at_tail) crc_q <= crc_d;
    end

    assign crc_run = crc_q;
endmodule

// File: rtl/msg_link_frame.sv
`timescale 1ns/1ps
module msg_link_frame
    import msg_link_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int LEN_MIN = 1,
    parameter int LEN_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic [LEN_W-1:0] len_field,
    output logic             at_hdr,
    output logic             at_tail,
    output logic             len_bad
);
    frame_st_e        st_q, st_d;
    logic [LEN_W-1:0] left_q;
    logic             bad_q;
    logic             len_illegal;

    assign len_illegal = (int'(len_field) < LEN_MIN) || (int'(len_field) > LEN_MAX);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HDR:  if (beat) st_d = (len_field == '0) ? ST_TAIL : ST_BODY;
            ST_BODY: if (beat && left_q == LEN_W'(1)) st_d = ST_TAIL;
            ST_TAIL: if (beat) st_d = ST_HDR;
            default: st_d = ST_HDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_HDR;
            left_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (beat && st_q == ST_HDR) begin
                left_q <= len_field;
                bad_q  <= len_illegal;
            end else if (beat && st_q == ST_BODY) begin
                left_q <= left_q - LEN_W'(1);
            end
        end
    end

    always_comb begin
        at_hdr  = 1'b0;
        at_tail = 1'b0;
        unique case (st_q)
            ST_HDR:  at_hdr  = 1'b1;
            ST_BODY: ;
            ST_TAIL: at_tail = 1'b1;
            default: at_hdr  = 1'b1;
        endcase
    end

    assign len_bad = bad_q;
endmodule

// File: rtl/msg_link_judge.sv
`timescale 1ns/1ps
module msg_link_judge #(
    parameter int CRC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_tail,
    input  logic             beat,
    input  logic             len_bad,
    input  logic [CRC_W-1:0] rx_crc,
    input  logic [CRC_W-1:0] calc_crc,
    output logic             rewrite,
    output logic             err_p,
    output logic             err_s,
    output logic [CNT_W-1:0] count
);
    logic is_compl, is_match, fresh;

    assign is_compl = (rx_crc == ~calc_crc);
    assign is_match = (rx_crc == calc_crc);
    assign fresh    = !is_compl && (!is_match || len_bad);
    assign rewrite  = at_tail && fresh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_p <= 1'b0;
            err_s <= 1'b0;
            count <= '0;
        end else begin
            err_p <= at_tail && beat && fresh;
            err_s <= at_tail && beat && is_compl;
            if (at_tail && beat) count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/msg_link_checker.sv
`timescale 1ns/1ps
module msg_link_checker #(
    parameter int          DATA_W  = 32,
    parameter int          CRC_W   = 16,
    parameter logic [15:0] POLY    = 16'h1021,
    parameter logic [15:0] SEED    = 16'hFFFF,
    parameter int          TAG_W   = 4,
    parameter int          LEN_W   = 4,
    parameter int          LEN_MIN = 1,
    parameter int          LEN_MAX = 5,
    parameter int          CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              err_primary,
    output logic              err_secondary,
    output logic [CNT_W-1:0]  msg_count
);
    localparam int LEN_LSB = TAG_W;
    localparam int LEN_MSB = TAG_W + LEN_W - 1;

    logic             beat, at_hdr, at_tail, len_bad, rewrite;
    logic [CRC_W-1:0] crc_run;

    assign beat      = in_valid && out_ready;
    assign in_ready  = out_ready;
    assign out_valid = in_valid;

    msg_link_frame #(.LEN_W(LEN_W), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) u_frame (
        .clk(clk), .rst_n(rst_n), .beat(beat),
        .len_field(in_data[LEN_MSB:LEN_LSB]),
        .at_hdr(at_hdr), .at_tail(at_tail), .len_bad(len_bad)
    );

    msg_link_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_crc (
        .clk(clk), .rst_n(rst_n), .beat(beat), .at_hdr(at_hdr), .at_tail(at_tail),
        .word(in_data), .crc_run(crc_run)
    );

    msg_link_judge #(.CRC_W(CRC_W), .CNT_W(CNT_W)) u_judge (
        .clk(clk), .rst_n(rst_n), .at_tail(at_tail), .beat(beat), .len_bad(len_bad),
        .rx_crc(in_data[CRC_W-1:0]), .calc_crc(crc_run), .rewrite(rewrite),
        .err_p(err_primary), .err_s(err_secondary), .count(msg_count)
    );

    assign out_data = rewrite ? {in_data[DATA_W-1:CRC_W], ~crc_run} : in_data;
endmodule

// File: rtl/msg_link_checker_sva.sv
`timescale 1ns/1ps
module msg_link_checker_sva #(
    parameter int HI_W  = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_ready,
    input logic [HI_W-1:0]  in_hi,
    input logic [HI_W-1:0]  out_hi,
    input logic             err_primary,
    input logic             err_secondary,
    input logic [CNT_W-1:0] msg_count
);
    p_one_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_primary && err_secondary));

    p_pulse_after_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_primary || err_secondary) |-> $past(in_valid && out_ready));

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_primary || err_secondary) |-> msg_count == CNT_W'($past(msg_count) + 1'b1));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_ready) |=> ($stable(msg_count) && !err_primary && !err_secondary));

    p_upper_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> out_hi == in_hi);
endmodule

bind msg_link_checker msg_link_checker_sva #(.HI_W(16), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_hi(in_data[31:16]), .out_hi(out_data[31:16]),
    .err_primary(err_primary), .err_secondary(err_secondary), .msg_count(msg_count)
);

// File: tb/msg_link_checker_tb_top.sv
`timescale 1ns/1ps
module msg_link_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        err_primary, err_secondary;
    logic [15:0] msg_count;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] exp_count = '0;
    bit done = 0;

    always #5 clk = ~clk;

    msg_link_checker dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .err_primary(err_primary), .err_secondary(err_secondary),
        .msg_count(msg_count)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // CRC per R2, written from the requirement
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] r = c;
        for (int b = 31; b >= 0; b--) begin
            if (r[15] != w[b]) r = (r << 1) ^ 16'h1021;
            else               r = r << 1;
        end
        return r;
    endfunction

    // drive one word, starting and ending at a falling edge
    task automatic beat(input logic [31:0] w, input int stall, input bit quiet, output logic [31:0] seen);
        in_valid = 1'b1;
        in_data  = w;
        for (int s = 0; s < stall; s++) begin
            out_ready = 1'b0;
            #1;
            check(in_ready == 1'b0 && out_valid == 1'b1, "R8 flow", {30'd0, in_ready, out_valid}, 32'd1);
            if (quiet) begin
                check(!err_primary && !err_secondary, "R9 stall pulse", {30'd0, err_primary, err_secondary}, 32'd0);
                check(msg_count == exp_count, "R9 stall count", {16'd0, msg_count}, {16'd0, exp_count});
            end
            @(negedge clk);
        end
        out_ready = 1'b1;
        #1;
        check(in_ready == 1'b1 && out_valid == 1'b1, "R8 flow", {30'd0, in_ready, out_valid}, 32'd3);
        seen = out_data;
        @(negedge clk);
    endtask

    // mode: 0 good trailer, 1 bad trailer, 2 complemented trailer, 3 data corrupted
    task automatic run_msg(input logic [23:0] route, input logic [3:0] len, input logic [3:0] tag,
                           input int mode, input int stall, input string req);
        logic [31:0] w;
        logic [31:0] seen;
        logic [15:0] c_tx, c_rx, tr_crc, exp_lo;
        logic [31:0] dw [16];
        bit bad_len, exp_p, exp_s;
        w = {route, len, tag};
        c_tx = ref_crc(16'hFFFF, w);
        for (int i = 0; i < int'(len); i++) begin
            dw[i] = 32'h5A000000 ^ {route[7:0], 24'd0} ^ (32'h01030507 * (i + 1));
            c_tx = ref_crc(c_tx, dw[i]);
        end
        if (mode == 3 && len != 0) dw[0] = dw[0] ^ 32'h00010000;
        c_rx = ref_crc(16'hFFFF, w);
        for (int i = 0; i < int'(len); i++) c_rx = ref_crc(c_rx, dw[i]);
        case (mode)
            1:       tr_crc = c_rx ^ 16'h0100;
            2:       tr_crc = ~c_rx;
            3:       tr_crc = c_tx;
            default: tr_crc = c_rx;
        endcase
        bad_len = (len < 1) || (len > 5);
        exp_s = (mode == 2);
        exp_p = !exp_s && (mode == 1 || mode == 3 || bad_len);
        exp_lo = exp_p ? ~c_rx : tr_crc;

        beat(w, 0, 0, seen);
        check(seen == w, {req, " R1 R8 header"}, seen, w);
        for (int i = 0; i < int'(len); i++) begin
            beat(dw[i], 0, 0, seen);
            check(seen == dw[i], {req, " R8 data"}, seen, dw[i]);
        end
        beat({16'hC0DE, tr_crc}, stall, 1, seen);
        check(seen == {16'hC0DE, exp_lo}, {req, " trailer"}, seen, {16'hC0DE, exp_lo});
        exp_count = exp_count + 16'd1;
        #1;
        check(err_primary == exp_p, {req, " primary"}, {31'd0, err_primary}, {31'd0, exp_p});
        check(err_secondary == exp_s, {req, " secondary"}, {31'd0, err_secondary}, {31'd0, exp_s});
        check(msg_count == exp_count, {req, " R7 count"}, {16'd0, msg_count}, {16'd0, exp_count});
    endtask

    task automatic idle(input string req);
        in_valid = 1'b0;
        @(negedge clk);
        #1;
        check(!err_primary && !err_secondary, {req, " pulse one cycle"}, {30'd0, err_primary, err_secondary}, 32'd0);
    endtask

    task automatic t_reset();
        #1;
        check(msg_count == 16'd0, "R10 count", {16'd0, msg_count}, 32'd0);
        check(!err_primary && !err_secondary, "R10 pulses", {30'd0, err_primary, err_secondary}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_msg(24'h123456, 4'd1, 4'h3, 0, 0, "R3 R2 len1");
        idle("R3");
        run_msg(24'h0A0B0C, 4'd5, 4'hF, 0, 2, "R3 R9 len5 stall");
        idle("R3");
        run_msg(24'h000001, 4'd2, 4'h1, 1, 3, "R4 bad trailer");
        idle("R4");
        run_msg(24'hFEDCBA, 4'd3, 4'h7, 3, 0, "R4 bad data");
        run_msg(24'h111111, 4'd4, 4'h2, 0, 0, "R3 back-to-back");
        run_msg(24'h222222, 4'd2, 4'h9, 2, 1, "R5 complement");
        idle("R5");
        run_msg(24'h333333, 4'd0, 4'h4, 0, 0, "R6 len0");
        run_msg(24'h444444, 4'd7, 4'h5, 0, 0, "R6 len7");
        run_msg(24'h555555, 4'd0, 4'h6, 2, 0, "R6 len0 complement");
        run_msg(24'h666666, 4'd15, 4'h8, 2, 0, "R6 len15 complement");
        run_msg(24'h777777, 4'd5, 4'hA, 0, 0, "R1 after illegal");
        idle("R7");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule